// File: doc/BRIEF.md
# Dual-Port Test-and-Set Interlock Monitor

This block is a small shared memory with two access ports and an interlock monitor in front of it. Either port can issue a plain read, a plain write, or an atomic test-and-set. A test-and-set reads a location and then writes 1 to it, but only when the value read was zero. The old value goes back to the requester, so a result of zero means the caller now owns the flag.

While a test-and-set is in flight, the monitor holds a lock on its address and records which port owns it. The other port receives a busy indication for that address and has to retry. If both ports present conflicting requests to the same address in the same cycle, port 0 wins. Traffic to other addresses flows with no interference, and plain reads and writes bypass the monitor unless their address is locked.

Top module: `tas_monitor`

## Requirements
- R1: After reset every location reads as zero, and no port shows `rsp_valid_o` or `busy_o` until it issues a request.
- R2: A read (`op_i` = 2'b00, or the unused code 2'b11) that is accepted in cycle t gives `rsp_valid_o` in cycle t+1, with the stored value on `rsp_data_o`.
- R3: A write (`op_i` = 2'b01) that is accepted in cycle t updates the location at the end of cycle t. It gives `rsp_valid_o` in cycle t+1, carrying the value the location held before the write.
- R4: A test-and-set (`op_i` = 2'b10) that is accepted in cycle t gives `rsp_valid_o` in cycle t+2, carrying the value the location held when the request was accepted.
- R5: A test-and-set stores 1 to its location only when the old value was zero. A location that held a nonzero value is left unchanged.
- R6: In the cycle after a port's test-and-set is accepted, the location is locked. A request from the other port to that address gets `busy_o`, and it is neither performed nor answered.
- R7: When both ports request the same address in the same cycle and at least one of them is a write or a test-and-set, port 0 is served and port 1 gets `busy_o`.
- R8: Requests to different, unlocked addresses are accepted on both ports in the same cycle without `busy_o`.
- R9: The lock is released after the execution cycle, so a request to that address two cycles after the test-and-set was accepted is accepted.
- R10: A port that requests anything while its own test-and-set is in its execution cycle gets `busy_o`.
- R11: `busy_o` of a port is only ever high while that port's `req_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 2 | Per-port request strobe |
| op_i | input | 2x2 | Per-port operation: 00 read, 01 write, 10 test-and-set, 11 read |
| addr_i | input | 2xAW | Per-port location address |
| wdata_i | input | 2xDW | Per-port write data |
| busy_o | output | 2 | Request refused this cycle; the port must retry |
| rsp_valid_o | output | 2 | Response strobe |
| rsp_data_o | output | 2xDW | Old or read value returned with the response |

## Verification
The assertions assume that a port does not rely on a refused request being remembered: a request is only counted as accepted in a cycle where its `busy_o` is low. They also assume that inputs are stable around the sampling clock edge. The stimulus drives all inputs on the falling edge. It retries freely, using a narrow address range so that locks and same-cycle clashes occur often, and it mixes zero and nonzero write data so that test-and-set sees both outcomes.

// File: rtl/tas_monitor_pkg.sv
package tas_monitor_pkg;
  localparam int unsigned NPORT = 2;
  localparam int unsigned OPW   = 2;

  typedef enum logic [OPW-1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_TAS = 2'd2,
    OP_RSV = 2'd3
  } op_e;

  function automatic logic op_modifies(input logic [OPW-1:0] op);
    return (op == OP_WR) || (op == OP_TAS);
  endfunction
endpackage

// File: rtl/tas_conflict.sv
module tas_conflict
  import tas_monitor_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic [NPORT-1:0]          req_i,
  input  logic [NPORT-1:0][OPW-1:0] op_i,
  input  logic [NPORT-1:0][AW-1:0]  addr_i,
  input  logic [NPORT-1:0]          exec_i,
  input  logic [NPORT-1:0][AW-1:0]  lock_addr_i,
  output logic [NPORT-1:0]          blocked_o
);
  logic [NPORT-1:0] held;
  logic             blk0;
  logic             clash;

  for (genvar p = 0; p < NPORT; p++) begin : g_held
    localparam int unsigned Q = NPORT - 1 - p;
    assign held[p] = exec_i[Q] && (lock_addr_i[Q] == addr_i[p]);
  end

  assign blk0  = exec_i[0] | held[0];
  // port 0 has priority on a same-cycle clash
  assign clash = req_i[0] && !blk0 && (addr_i[0] == addr_i[1]) &&
                 (op_modifies(op_i[0]) || op_modifies(op_i[1]));

  assign blocked_o[0] = blk0;
  assign blocked_o[1] = exec_i[1] | held[1] | clash;
endmodule

// File: rtl/tas_lock_unit.sv
module tas_lock_unit
  import tas_monitor_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           accept_i,
  input  logic [OPW-1:0] op_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  rd_data_i,
  output logic           exec_o,
  output logic [AW-1:0]  lock_addr_o,
  output logic           st_en_o,
  output logic [AW-1:0]  st_addr_o,
  output logic           rsp_valid_o,
  output logic [DW-1:0]  rsp_data_o
);
  logic          exec_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] old_q;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_data_q;
  logic          take_tas;

  assign take_tas = accept_i && (op_i == OP_TAS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_q      <= 1'b0;
      addr_q      <= '0;
      old_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      exec_q <= take_tas;
      if (take_tas) begin
        addr_q <= addr_i;
        old_q  <= rd_data_i;
      end
      if (accept_i && !take_tas) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rd_data_i;
      end else if (exec_q) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= old_q;
      end else begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign exec_o      = exec_q;
  assign lock_addr_o = addr_q;
  assign st_en_o     = exec_q && (old_q == '0);
  assign st_addr_o   = addr_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/tas_store.sv
module tas_store #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8,
  parameter int unsigned NW = 4,
  parameter int unsigned NR = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NW-1:0]          we_i,
  input  logic [NW-1:0][AW-1:0]  waddr_i,
  input  logic [NW-1:0][DW-1:0]  wdata_i,
  input  logic [NR-1:0][AW-1:0]  raddr_i,
  output logic [NR-1:0][DW-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int w = 0; w < NW; w++) begin
        if (we_i[w]) mem_q[waddr_i[w]] <= wdata_i[w];
      end
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    assign rdata_o[r] = mem_q[raddr_i[r]];
  end
endmodule

// File: rtl/tas_monitor.sv
module tas_monitor
  import tas_monitor_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NPORT-1:0]          req_i,
  input  logic [NPORT-1:0][OPW-1:0] op_i,
  input  logic [NPORT-1:0][AW-1:0]  addr_i,
  input  logic [NPORT-1:0][DW-1:0]  wdata_i,
  output logic [NPORT-1:0]          busy_o,
  output logic [NPORT-1:0]          rsp_valid_o,
  output logic [NPORT-1:0][DW-1:0]  rsp_data_o
);
  localparam int unsigned NW = 2 * NPORT;

  logic [NPORT-1:0]         blocked;
  logic [NPORT-1:0]         accept;
  logic [NPORT-1:0]         exec;
  logic [NPORT-1:0][AW-1:0] lock_addr;
  logic [NPORT-1:0]         st_en;
  logic [NPORT-1:0][AW-1:0] st_addr;
  logic [NPORT-1:0][DW-1:0] rd_data;
  logic [NW-1:0]            we;
  logic [NW-1:0][AW-1:0]    waddr;
  logic [NW-1:0][DW-1:0]    wdata;

  tas_conflict #(.AW(AW)) conflict_i (
    .req_i       (req_i),
    .op_i        (op_i),
    .addr_i      (addr_i),
    .exec_i      (exec),
    .lock_addr_i (lock_addr),
    .blocked_o   (blocked)
  );

  assign accept = req_i & ~blocked;
  assign busy_o = req_i & blocked;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    tas_lock_unit #(.AW(AW), .DW(DW)) unit_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .accept_i    (accept[p]),
      .op_i        (op_i[p]),
      .addr_i      (addr_i[p]),
      .rd_data_i   (rd_data[p]),
      .exec_o      (exec[p]),
      .lock_addr_o (lock_addr[p]),
      .st_en_o     (st_en[p]),
      .st_addr_o   (st_addr[p]),
      .rsp_valid_o (rsp_valid_o[p]),
      .rsp_data_o  (rsp_data_o[p])
    );
    // plain writes on low slots, conditional stores on high slots
    assign we[p]          = accept[p] && (op_i[p] == OP_WR);
    assign waddr[p]       = addr_i[p];
    assign wdata[p]       = wdata_i[p];
    assign we[NPORT+p]    = st_en[p];
    assign waddr[NPORT+p] = st_addr[p];
    assign wdata[NPORT+p] = DW'(1);
  end

  tas_store #(.AW(AW), .DW(DW), .NW(NW), .NR(NPORT)) store_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (addr_i),
    .rdata_o (rd_data)
  );
endmodule

// File: rtl/tas_monitor_chk.sv
module tas_monitor_chk
  import tas_monitor_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NPORT-1:0]          req_i,
  input logic [NPORT-1:0][OPW-1:0] op_i,
  input logic [NPORT-1:0][AW-1:0]  addr_i,
  input logic [NPORT-1:0]          busy_o,
  input logic [NPORT-1:0]          rsp_valid_o
);
  logic [NPORT-1:0] acc_tas;
  logic [NPORT-1:0] acc_rw;

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    localparam int unsigned Q = NPORT - 1 - p;
    assign acc_tas[p] = req_i[p] && !busy_o[p] && (op_i[p] == OP_TAS);
    assign acc_rw[p]  = req_i[p] && !busy_o[p] && (op_i[p] != OP_TAS);

    // R11
    busy_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o[p] |-> req_i[p]);
    // R2
    rw_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_rw[p] |=> rsp_valid_o[p]);
    // R4
    tas_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_tas[p] |-> ##2 rsp_valid_o[p]);
    // R10
    own_exec_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_tas[p] |=> (req_i[p] -> busy_o[p]));
    // R6
    lock_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_tas[p] |=> ((req_i[Q] && (addr_i[Q] == $past(addr_i[p]))) -> busy_o[Q]));
  end

  // R7
  clash_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i[0] && !busy_o[0] && (op_i[0] == OP_TAS) && req_i[1] &&
     (addr_i[0] == addr_i[1])) |-> busy_o[1]);
endmodule

bind tas_monitor tas_monitor_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .op_i        (op_i),
  .addr_i      (addr_i),
  .busy_o      (busy_o),
  .rsp_valid_o (rsp_valid_o)
);

// File: tb/tas_monitor_tb_top.sv
`timescale 1ns/1ps
module tas_monitor_tb_top;
  import tas_monitor_pkg::*;

  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;
  localparam int unsigned DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]          req;
  logic [1:0][1:0]     op;
  logic [1:0][AW-1:0]  addr;
  logic [1:0][DW-1:0]  wdata;
  logic [1:0]          busy;
  logic [1:0]          rsp_valid;
  logic [1:0][DW-1:0]  rsp_data;

  tas_monitor #(.AW(AW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  string tag_ovr = "";

  logic [DW-1:0] m_mem [DEPTH];
  logic          m_exec [2];
  logic [AW-1:0] m_la [2];
  logic [DW-1:0] m_old [2];
  logic          m_rv [2];
  logic [DW-1:0] m_rd [2];
  string         m_rt [2];

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic string pick(input string t);
    return (tag_ovr != "") ? tag_ovr : t;
  endfunction

  task automatic step(input bit r0, input logic [1:0] o0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                      input bit r1, input logic [1:0] o1, input logic [AW-1:0] a1, input logic [DW-1:0] d1);
    bit r[2]; logic [1:0] o[2]; logic [AW-1:0] a[2]; logic [DW-1:0] d[2];
    bit held[2]; bit blk[2]; bit acc[2]; bit clash;
    logic nrv[2]; logic [DW-1:0] nrd[2]; string nrt[2];
    logic nex[2]; logic [AW-1:0] nla[2]; logic [DW-1:0] nold[2];
    string bt;
    r[0] = r0; o[0] = o0; a[0] = a0; d[0] = d0;
    r[1] = r1; o[1] = o1; a[1] = a1; d[1] = d1;
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      chk(rsp_valid[p] === m_rv[p], pick(m_rt[p]), $sformatf("rsp_valid[%0d]", p), int'(rsp_valid[p]), int'(m_rv[p]));
      if (m_rv[p])
        chk(rsp_data[p] === m_rd[p], pick(m_rt[p]), $sformatf("rsp_data[%0d]", p), int'(rsp_data[p]), int'(m_rd[p]));
    end
    for (int p = 0; p < 2; p++) begin
      req[p] = r[p]; op[p] = o[p]; addr[p] = a[p]; wdata[p] = d[p];
    end
    #1;
    for (int p = 0; p < 2; p++) held[p] = m_exec[1-p] && (m_la[1-p] == a[p]);
    blk[0] = m_exec[0] || held[0];
    clash = r[0] && !blk[0] && (a[0] == a[1]) &&
            (o[0] == OP_WR || o[0] == OP_TAS || o[1] == OP_WR || o[1] == OP_TAS);
    blk[1] = m_exec[1] || held[1] || clash;
    for (int p = 0; p < 2; p++) begin
      if (!r[p]) bt = "R11";
      else if (m_exec[p]) bt = "R10";
      else if (held[p]) bt = "R6";
      else if (p == 1 && clash) bt = "R7";
      else bt = "R8";
      chk(busy[p] === (r[p] && blk[p]), pick(bt), $sformatf("busy[%0d]", p),
          int'(busy[p]), int'(r[p] && blk[p]));
      acc[p] = r[p] && !blk[p];
    end
    for (int p = 0; p < 2; p++) begin
      nrt[p] = pick("R2"); nrd[p] = m_rd[p];
      nex[p] = acc[p] && (o[p] == OP_TAS);
      nla[p] = nex[p] ? a[p] : m_la[p];
      nold[p] = nex[p] ? m_mem[a[p]] : m_old[p];
      if (acc[p] && o[p] != OP_TAS) begin
        nrv[p] = 1'b1; nrd[p] = m_mem[a[p]];
        nrt[p] = pick((o[p] == OP_WR) ? "R3" : "R2");
      end else if (m_exec[p]) begin
        nrv[p] = 1'b1; nrd[p] = m_old[p]; nrt[p] = pick("R4");
      end else begin
        nrv[p] = 1'b0;
      end
    end
    for (int p = 0; p < 2; p++)
      if (m_exec[p] && m_old[p] == '0) m_mem[m_la[p]] = DW'(1);
    for (int p = 0; p < 2; p++)
      if (acc[p] && o[p] == OP_WR) m_mem[a[p]] = d[p];
    for (int p = 0; p < 2; p++) begin
      m_rv[p] = nrv[p]; m_rd[p] = nrd[p]; m_rt[p] = nrt[p];
      m_exec[p] = nex[p]; m_la[p] = nla[p]; m_old[p] = nold[p];
    end
  endtask

  task automatic idle();
    step(0, OP_RD, '0, '0, 0, OP_RD, '0, '0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int s;
    s = $urandom(32'h5eed);
    req = '0; op = '0; addr = '0; wdata = '0;
    for (int i = 0; i < int'(DEPTH); i++) m_mem[i] = '0;
    for (int p = 0; p < 2; p++) begin
      m_exec[p] = 0; m_la[p] = '0; m_old[p] = '0; m_rv[p] = 0; m_rd[p] = '0; m_rt[p] = "R1";
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and cleared storage
    tag_ovr = "R1";
    idle();
    for (int i = 0; i < int'(DEPTH); i++) step(1, OP_RD, AW'(i), '0, 0, OP_RD, '0, '0);
    idle(); idle();
    tag_ovr = "";

    // R3 write then R5 test-and-set on nonzero leaves it alone
    step(1, OP_WR, 4'd5, 8'h3c, 0, OP_RD, '0, '0);
    tag_ovr = "R5";
    step(1, OP_TAS, 4'd5, '0, 0, OP_RD, '0, '0);
    idle();
    step(0, OP_RD, '0, '0, 1, OP_RD, 4'd5, '0);
    idle(); idle();
    tag_ovr = "";

    // R4: first TAS on zero returns 0, second returns 1
    step(0, OP_RD, '0, '0, 1, OP_TAS, 4'd2, '0);
    idle();
    step(0, OP_RD, '0, '0, 1, OP_TAS, 4'd2, '0);
    idle(); idle();

    // R7: same-cycle TAS clash, port 0 wins
    step(1, OP_TAS, 4'd7, '0, 1, OP_TAS, 4'd7, '0);
    idle(); idle();

    // R6, R10: lock window; R11 with request low
    step(1, OP_TAS, 4'd9, '0, 0, OP_RD, '0, '0);
    step(1, OP_RD, 4'd9, '0, 1, OP_RD, 4'd9, '0);
    tag_ovr = "R9";
    step(0, OP_RD, '0, '0, 1, OP_RD, 4'd9, '0);
    tag_ovr = "";
    idle(); idle();

    // R8: concurrent writes to different addresses
    step(1, OP_WR, 4'd10, 8'h11, 1, OP_WR, 4'd11, 8'h22);
    step(1, OP_RD, 4'd10, '0, 1, OP_RD, 4'd11, '0);
    idle(); idle();

    for (int i = 0; i < 3000; i++) begin
      bit r0, r1; logic [1:0] o0, o1; logic [AW-1:0] a0, a1; logic [DW-1:0] d0, d1;
      r0 = ($urandom % 10) < 7; r1 = ($urandom % 10) < 7;
      o0 = 2'($urandom % 4); o1 = 2'($urandom % 4);
      a0 = AW'($urandom % 4); a1 = AW'($urandom % 4);
      d0 = ($urandom % 3 == 0) ? '0 : DW'($urandom);
      d1 = ($urandom % 3 == 0) ? '0 : DW'($urandom);
      step(r0, o0, a0, d0, r1, o1, a1, d1);
    end
    idle(); idle(); idle();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule